// File: doc/BRIEF.md
# Set-Indexed Translation Cache

This block keeps a small number of recently used page table entries close to the address path. A client offers a virtual page number on the lookup port. One clock later the block answers with hit or miss, the cached physical frame number and the supervisor-only permission bit. A miss opens a page-table walk request toward an external walker. When the walker strobes back a valid entry, the block writes it into the set chosen by the page number. A faulting walk result closes the request and leaves the contents unchanged.

The page number is split into two parts. The low bits pick one of a power-of-two number of sets, and the remaining upper bits form the tag. Each set holds two ways, and each way caches exactly one entry. On a fill, an empty way is used first. When both ways are occupied, a per-set recency bit picks the way that was used less recently. A flush pulse empties the whole structure in a single cycle.

Top module: `tlb_set_assoc`

## Requirements
- R1: After reset, `rsp_valid` and `walk_req` are 0, and every entry is empty, so a first lookup of any page number reports a miss.
- R2: The set index is the `SET_BITS` least significant bits of the page number, and the tag is all bits above them. A page number that shares an index with a cached entry but differs in the tag reports a miss.
- R3: A lookup strobed in cycle N is answered in cycle N+1. `rsp_valid` is 1 exactly in the cycle after `lkp_valid` was 1. `rsp_hit` is only 1 together with `rsp_valid`. On a hit, `rsp_pfn` and `rsp_sup` are the frame number and permission bit that were installed for that page number.
- R4: A miss that occurs while no walk is outstanding sets `walk_req` to 1 in the same cycle as the miss response, with `walk_vpn` equal to the missed page number. Both stay unchanged until a fill strobe or a flush arrives.
- R5: A fill strobe with `fill_ok`=1 while a walk is outstanding installs `fill_pfn`/`fill_sup` under `walk_vpn` and drops `walk_req` in the next cycle. A following lookup of that page number hits.
- R6: A fill strobe with `fill_ok`=0 (a faulting walk) drops `walk_req` in the next cycle and installs nothing. The page number still misses afterwards.
- R7: A fill goes into an empty way of the indexed set when one exists, so two page numbers with the same index and different tags can both hit.
- R8: When both ways of the set are occupied, a fill replaces the way that was not used most recently. Both a hit and a fill count as a use.
- R9: A flush pulse empties every entry and cancels any outstanding walk, so `walk_req` is 0 in the next cycle. A lookup in the same cycle as the flush reports a miss and starts no walk. A fill strobe after the cancel installs nothing.
- R10: A miss while a walk is outstanding leaves `walk_req` and `walk_vpn` unchanged. A fill strobe while no walk is outstanding is ignored.
- R11: Sets are independent. A fill into one set never removes an entry cached in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Single-cycle pulse that empties all entries and cancels any walk |
| lkp_valid | input | 1 | Lookup strobe |
| lkp_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Registered lookup answer is present |
| rsp_hit | output | 1 | The answer is a hit |
| rsp_pfn | output | PFN_W | Cached frame number on a hit, 0 on a miss |
| rsp_sup | output | 1 | Cached supervisor-only bit on a hit, 0 on a miss |
| walk_req | output | 1 | Walk request is outstanding |
| walk_vpn | output | VPN_W | Page number being walked |
| fill_valid | input | 1 | Walker result strobe |
| fill_ok | input | 1 | 1 when the result is a valid entry, 0 when the walk faulted |
| fill_pfn | input | PFN_W | Frame number returned by the walker |
| fill_sup | input | 1 | Supervisor-only bit returned by the walker |

## Verification
Corrupt tag or index storage shows up on the next lookup of an affected page number, one cycle after the strobe. It appears either as a spurious hit carrying the wrong frame number, or as a miss that raises a walk for a page number that should have hit. A wrong recency bit stays hidden until the third distinct tag is filled into the same set, after which the wrong survivor misses. This is why the bench drives every set through a three-tag sequence with an intervening hit. A stuck walk state is visible at once on `walk_req`, and a missed flush is exposed by the first lookup after it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Associativity is fixed by the single-bit-per-set recency scheme.
  localparam int TLB_WAYS = 2;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_WAIT = 1'b1
  } walk_state_e;
endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
  parameter int SET_BITS = 2,
  parameter int TAG_W    = 18,
  parameter int PFN_W    = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic [SET_BITS-1:0] rd_idx,
  input  logic [TAG_W-1:0]    rd_tag,
  output logic                rd_match,
  output logic [PFN_W-1:0]    rd_pfn,
  output logic                rd_sup,
  input  logic [SET_BITS-1:0] vic_idx,
  output logic                vic_valid,
  input  logic                wr_en,
  input  logic [SET_BITS-1:0] wr_idx,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [PFN_W-1:0]    wr_pfn,
  input  logic                wr_sup
);
  localparam int SETS   = 1 << SET_BITS;
  localparam int LINE_W = TAG_W + PFN_W + 1;

  // Payload array without reset so it maps onto RAM; valid bits kept in flops.
  logic [LINE_W-1:0] line_mem [SETS];
  logic [SETS-1:0]   valid_q;
  logic [LINE_W-1:0] rd_line;

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      line_mem[wr_idx] <= {wr_tag, wr_pfn, wr_sup};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_comb begin
    rd_line   = line_mem[rd_idx];
    rd_match  = valid_q[rd_idx] && (rd_line[LINE_W-1 -: TAG_W] == rd_tag);
    rd_pfn    = rd_line[PFN_W:1];
    rd_sup    = rd_line[0];
    vic_valid = valid_q[vic_idx];
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int SET_BITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                use_en,
  input  logic [SET_BITS-1:0] use_idx,
  input  logic                use_way,
  input  logic                fill_en,
  input  logic [SET_BITS-1:0] fill_idx,
  input  logic [1:0]          fill_set_valid,
  output logic                victim
);
  localparam int SETS = 1 << SET_BITS;

  // replace_q[s] names the way to evict next in set s.
  logic [SETS-1:0] replace_q;

  always_comb begin
    if (!fill_set_valid[0]) begin
      victim = 1'b0;
    end else if (!fill_set_valid[1]) begin
      victim = 1'b1;
    end else begin
      victim = replace_q[fill_idx];
    end
  end

  generate
    for (genvar s = 0; s < SETS; s++) begin : g_set
      always_ff @(posedge clk) begin
        if (rst) begin
          replace_q[s] <= 1'b0;
        end else if (fill_en && (fill_idx == s)) begin
          replace_q[s] <= ~victim;
        end else if (use_en && (use_idx == s)) begin
          replace_q[s] <= ~use_way;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tlb_walk_ctl.sv
module tlb_walk_ctl
  import tlb_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             miss_seen,
  input  logic [VPN_W-1:0] miss_vpn,
  input  logic             fill_valid,
  input  logic             fill_ok,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  output logic             install
);
  walk_state_e      state_q;
  logic [VPN_W-1:0] vpn_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state_q <= WALK_IDLE;
    end else begin
      unique case (state_q)
        WALK_IDLE: if (miss_seen) state_q <= WALK_WAIT;
        WALK_WAIT: if (fill_valid) state_q <= WALK_IDLE;
        default:   state_q <= WALK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vpn_q <= '0;
    end else if (state_q == WALK_IDLE && miss_seen && !flush) begin
      vpn_q <= miss_vpn;
    end
  end

  assign walk_req = (state_q == WALK_WAIT);
  assign walk_vpn = vpn_q;
  assign install  = walk_req && fill_valid && fill_ok && !flush;
endmodule

// File: rtl/tlb_set_assoc.sv
module tlb_set_assoc
  import tlb_pkg::*;
#(
  parameter int VPN_W    = 20,
  parameter int PFN_W    = 20,
  parameter int SET_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             lkp_valid,
  input  logic [VPN_W-1:0] lkp_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_sup,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             fill_valid,
  input  logic             fill_ok,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_sup
);
  localparam int TAG_W = VPN_W - SET_BITS;

  logic [SET_BITS-1:0] lkp_idx, fill_idx;
  logic [TAG_W-1:0]    lkp_tag, fill_tag;
  logic [TLB_WAYS-1:0] way_match, way_vic_valid, way_wr;
  logic [PFN_W-1:0]    way_pfn [TLB_WAYS];
  logic [TLB_WAYS-1:0] way_sup;
  logic                victim, install, hit_now, miss_now, hit_way;
  logic [PFN_W-1:0]    hit_pfn;
  logic                hit_sup;

  assign lkp_idx  = lkp_vpn[SET_BITS-1:0];
  assign lkp_tag  = lkp_vpn[VPN_W-1:SET_BITS];
  assign fill_idx = walk_vpn[SET_BITS-1:0];
  assign fill_tag = walk_vpn[VPN_W-1:SET_BITS];

  generate
    for (genvar w = 0; w < TLB_WAYS; w++) begin : g_way
      assign way_wr[w] = install && (victim == w[0]);
      tlb_way_store #(
        .SET_BITS(SET_BITS), .TAG_W(TAG_W), .PFN_W(PFN_W)
      ) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .rd_idx   (lkp_idx),
        .rd_tag   (lkp_tag),
        .rd_match (way_match[w]),
        .rd_pfn   (way_pfn[w]),
        .rd_sup   (way_sup[w]),
        .vic_idx  (fill_idx),
        .vic_valid(way_vic_valid[w]),
        .wr_en    (way_wr[w]),
        .wr_idx   (fill_idx),
        .wr_tag   (fill_tag),
        .wr_pfn   (fill_pfn),
        .wr_sup   (fill_sup)
      );
    end
  endgenerate

  always_comb begin
    hit_pfn = '0;
    hit_sup = 1'b0;
    for (int w = 0; w < TLB_WAYS; w++) begin
      if (way_match[w]) begin
        hit_pfn = hit_pfn | way_pfn[w];
        hit_sup = hit_sup | way_sup[w];
      end
    end
    hit_way  = way_match[1];
    hit_now  = lkp_valid && !flush && (|way_match);
    miss_now = lkp_valid && !flush && !(|way_match);
  end

  tlb_victim_sel #(.SET_BITS(SET_BITS)) u_victim (
    .clk           (clk),
    .rst           (rst),
    .use_en        (hit_now),
    .use_idx       (lkp_idx),
    .use_way       (hit_way),
    .fill_en       (install),
    .fill_idx      (fill_idx),
    .fill_set_valid(way_vic_valid),
    .victim        (victim)
  );

  tlb_walk_ctl #(.VPN_W(VPN_W)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .miss_seen (miss_now),
    .miss_vpn  (lkp_vpn),
    .fill_valid(fill_valid),
    .fill_ok   (fill_ok),
    .walk_req  (walk_req),
    .walk_vpn  (walk_vpn),
    .install   (install)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pfn   <= '0;
      rsp_sup   <= 1'b0;
    end else begin
      rsp_valid <= lkp_valid;
      rsp_hit   <= hit_now;
      rsp_pfn   <= hit_now ? hit_pfn : '0;
      rsp_sup   <= hit_now ? hit_sup : 1'b0;
    end
  end
endmodule

// File: rtl/tlb_set_assoc_chk.sv
module tlb_set_assoc_chk #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             lkp_valid,
  input logic [VPN_W-1:0] lkp_vpn,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [PFN_W-1:0] rsp_pfn,
  input logic             walk_req,
  input logic [VPN_W-1:0] walk_vpn,
  input logic             fill_valid
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !walk_req));

  assert_rsp_latency_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rsp_valid == $past(lkp_valid)));

  assert_hit_has_valid_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  assert_miss_pfn_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0));

  assert_walk_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(walk_req) |-> (rsp_valid && !rsp_hit && walk_vpn == $past(lkp_vpn)));

  assert_walk_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !fill_valid && !flush) |=> (walk_req && $stable(walk_vpn)));

  assert_walk_close_R6: assert property (@(posedge clk) disable iff (rst)
    (walk_req && fill_valid) |=> !walk_req);

  assert_flush_cancel_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!walk_req && !rsp_hit));
endmodule

bind tlb_set_assoc tlb_set_assoc_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .lkp_valid (lkp_valid),
  .lkp_vpn   (lkp_vpn),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_pfn   (rsp_pfn),
  .walk_req  (walk_req),
  .walk_vpn  (walk_vpn),
  .fill_valid(fill_valid)
);

// File: tb/tlb_set_assoc_tb.sv
module tlb_set_assoc_tb;
  localparam int VPN_W = 20;
  localparam int PFN_W = 20;
  localparam int SET_BITS = 2;
  localparam int SETS = 1 << SET_BITS;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             flush = 1'b0;
  logic             lkp_valid = 1'b0;
  logic [VPN_W-1:0] lkp_vpn = '0;
  logic             rsp_valid, rsp_hit, rsp_sup, walk_req;
  logic [PFN_W-1:0] rsp_pfn;
  logic [VPN_W-1:0] walk_vpn;
  logic             fill_valid = 1'b0;
  logic             fill_ok = 1'b0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic             fill_sup = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tlb_set_assoc #(.VPN_W(VPN_W), .PFN_W(PFN_W), .SET_BITS(SET_BITS)) u_dut (
    .clk(clk), .rst(rst), .flush(flush),
    .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_sup(rsp_sup),
    .walk_req(walk_req), .walk_vpn(walk_vpn),
    .fill_valid(fill_valid), .fill_ok(fill_ok), .fill_pfn(fill_pfn), .fill_sup(fill_sup)
  );

  function automatic logic [VPN_W-1:0] mk_vpn(input logic [VPN_W-SET_BITS-1:0] tag, input int s);
    return {tag, s[SET_BITS-1:0]};
  endfunction
  function automatic logic [PFN_W-1:0] pfn_of(input logic [VPN_W-1:0] v);
    return v ^ 20'hC3A5F;
  endfunction
  function automatic logic sup_of(input logic [VPN_W-1:0] v);
    return v[5] ^ v[2];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v);
    @(negedge clk);
    lkp_valid = 1'b1;
    lkp_vpn   = v;
    @(negedge clk);
    lkp_valid = 1'b0;
  endtask

  task automatic expect_hit(input logic [VPN_W-1:0] v, input string req);
    lookup(v);
    check(rsp_valid && rsp_hit, req, {rsp_valid, rsp_hit}, 2'b11);
    check(rsp_pfn == pfn_of(v) && rsp_sup == sup_of(v), req, {rsp_sup, rsp_pfn}, {sup_of(v), pfn_of(v)});
  endtask

  // walk_exp: the page number that must be under walk after this miss.
  task automatic expect_miss(input logic [VPN_W-1:0] v, input logic [VPN_W-1:0] walk_exp, input string req);
    lookup(v);
    check(rsp_valid && !rsp_hit, req, {rsp_valid, rsp_hit}, 2'b10);
    check(walk_req && walk_vpn == walk_exp, "R4", {walk_req, walk_vpn}, {1'b1, walk_exp});
  endtask

  task automatic fill(input bit ok, input logic [VPN_W-1:0] v);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_ok    = ok;
    fill_pfn   = pfn_of(v);
    fill_sup   = sup_of(v);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [VPN_W-1:0] a, b, c, d, e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!rsp_valid && !walk_req, "R1", {rsp_valid, walk_req}, 0);

    // R1/R2/R4/R5/R7/R8 per set: three tags with a recency-changing hit.
    for (int s = 0; s < SETS; s++) begin
      a = mk_vpn(18'h00A00 + 18'(s * 3), s);
      b = mk_vpn(18'h2F0F0 ^ 18'(s), s);
      c = mk_vpn(18'h15555 + 18'(s), s);
      expect_miss(a, a, "R1");
      repeat (2) @(negedge clk);
      check(walk_req && walk_vpn == a, "R4", {walk_req, walk_vpn}, {1'b1, a});
      fill(1'b1, a);
      check(!walk_req, "R5", walk_req, 0);
      expect_hit(a, "R5");
      expect_miss(b, b, "R2");
      fill(1'b1, b);
      expect_hit(b, "R7");
      expect_hit(a, "R7");
      expect_miss(c, c, "R2");
      fill(1'b1, c);
      expect_hit(c, "R8");
      expect_hit(a, "R8");
      expect_miss(b, b, "R8");
      fill(1'b0, b);
      check(!walk_req, "R6", walk_req, 0);
      fill(1'b1, b);
      expect_miss(b, b, "R10");
      fill(1'b0, b);
    end

    // R11: every set still holds its own two survivors.
    for (int s = 0; s < SETS; s++) begin
      expect_hit(mk_vpn(18'h00A00 + 18'(s * 3), s), "R11");
      expect_hit(mk_vpn(18'h15555 + 18'(s), s), "R11");
    end

    // R10: a second miss during a walk keeps the first page number.
    d = mk_vpn(18'h3ABCD, 1);
    e = mk_vpn(18'h01234, 2);
    expect_miss(d, d, "R4");
    expect_miss(e, d, "R10");
    fill(1'b1, d);
    expect_hit(d, "R5");
    // R6: faulting walk installs nothing.
    expect_miss(e, e, "R6");
    fill(1'b0, e);
    check(!walk_req, "R6", walk_req, 0);
    expect_miss(e, e, "R6");
    fill(1'b0, e);

    // R9: flush with a lookup in the same cycle.
    @(negedge clk);
    flush = 1'b1;
    lkp_valid = 1'b1;
    lkp_vpn = d;
    @(negedge clk);
    flush = 1'b0;
    lkp_valid = 1'b0;
    check(rsp_valid && !rsp_hit && !walk_req, "R9", {rsp_valid, rsp_hit, walk_req}, 3'b100);

    // R9: flush cancels a pending walk; the late fill is dropped.
    expect_miss(e, e, "R9");
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(!walk_req, "R9", walk_req, 0);
    fill(1'b1, e);

    // R9: every previously cached page number is gone.
    for (int s = 0; s < SETS; s++) begin
      a = mk_vpn(18'h00A00 + 18'(s * 3), s);
      c = mk_vpn(18'h15555 + 18'(s), s);
      expect_miss(a, a, "R9");
      fill(1'b0, a);
      expect_miss(c, c, "R9");
      fill(1'b0, c);
    end
    expect_miss(e, e, "R9");
    fill(1'b0, e);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule